// File: doc/BRIEF.md
# Frame Validity and Bit Error Monitor

This block follows a serial bus frame one sampled bit at a time. It decides when the frame counts as valid. A node that is transmitting and a node that is only receiving reach that decision at different points. The block also compares each bit the node drives with the level it reads back from the bus, and it flags a bit error when the two disagree. Two cases are excused: readback in the arbitration field and in the acknowledge slot.

A bit-timing stage supplies a one-cycle `sample` strobe, the bit being sent and the bit sampled back. A framing stage supplies a 3-bit segment code and an error input that gathers the other error sources (stuffing, CRC, form). After a transmission is corrupted, the block holds a retransmit request whenever the bus is idle. The request stays pending until the next frame that this node starts.

Top module: `frame_check_monitor`

## Requirements
- R1: On a `sample` strobe with `tx_active` high, `bit_error` pulses for exactly the following cycle when `tx_bit` differs from `rx_bit`, except in the cases R2 and R3 excuse. Without `sample`, `bit_error` stays low.
- R2: In segment code 2 (arbitration), sending recessive (1) and reading dominant (0) raises no `bit_error`; instead `arb_lost` pulses for the following cycle.
- R3: In segment code 6 (acknowledge slot), sending 1 and reading 0 raises neither `bit_error` nor `arb_lost`.
- R4: Sending 0 and reading 1 is a bit error in every segment, arbitration included.
- R5: A node with `tx_active` low gets one `rx_valid` pulse in the cycle after the sample of end-of-frame bit number EOF_LEN-2 (counting from 0; segment code 7). This requires that no error occurred from start of frame (code 1) through that bit. `rx_valid` never pulses while `tx_active` is high.
- R6: A dominant level on any end-of-frame bit before the last counts as an error and suppresses `rx_valid`. The level of the last end-of-frame bit has no effect on the receiver outcome.
- R7: A node with `tx_active` high gets one `tx_valid` pulse in the cycle after the sample of end-of-frame bit EOF_LEN-1. This requires that no error occurred from start of frame through that last bit.
- R8: An error from `err_in` or from R1 at any sample of a frame suppresses validity for the rest of that frame. A start-of-frame sample clears the error history.
- R9: An error while `tx_active` is high sets a pending retransmit. `retx_req` is high while it is pending and the segment code is 0 (idle). A start-of-frame sample with `tx_active` high clears it.
- R10: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 1 | One-cycle strobe at each bit sample point |
| seg | input | 3 | Segment: 0 idle, 1 SOF, 2 arbitration, 3 control/data, 4 CRC, 5 delimiter, 6 ACK slot, 7 EOF |
| tx_active | input | 1 | Node is transmitting the current frame |
| tx_bit | input | 1 | Level driven by this node (1 recessive) |
| rx_bit | input | 1 | Level sampled from the bus |
| err_in | input | 1 | Other error detected at this sample |
| bit_error | output | 1 | Bit error pulse |
| arb_lost | output | 1 | Arbitration loss pulse |
| tx_valid | output | 1 | Frame valid for transmitter pulse |
| rx_valid | output | 1 | Frame valid for receiver pulse |
| retx_req | output | 1 | Retransmission requested while bus idle |

## Verification
The bench builds the block with EOF_LEN at its default of 7. With that length, the receiver validity point falls on end-of-frame bit 5 and the transmitter point on bit 6. Both are reached and told apart in frames of a few dozen samples. This length also leaves room to place a dominant bit or an injected error before, at and after each of those points.

// File: rtl/frame_check_monitor.sv
module frame_check_monitor #(
  parameter int EOF_LEN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic [2:0] seg,
  input  logic       tx_active,
  input  logic       tx_bit,
  input  logic       rx_bit,
  input  logic       err_in,
  output logic       bit_error,
  output logic       arb_lost,
  output logic       tx_valid,
  output logic       rx_valid,
  output logic       retx_req
);
  localparam int CW = $clog2(EOF_LEN + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_SOF = 3'd1, S_ARB = 3'd2, S_ACK = 3'd6, S_EOF = 3'd7;

  logic [CW-1:0] eof_idx;
  logic          hit, pending;

  wire in_eof   = (seg == S_EOF);
  wire eof_last = in_eof && (eof_idx == CW'(EOF_LEN - 1));
  wire eof_prev = in_eof && (eof_idx == CW'(EOF_LEN - 2));
  wire rec_dom  = tx_bit && !rx_bit;
  wire excused  = rec_dom && (seg == S_ARB || seg == S_ACK);
  wire berr     = tx_active && (tx_bit != rx_bit) && !excused;
  wire form_err = in_eof && !rx_bit && !eof_last;
  wire err_now  = err_in || berr || form_err;
  wire hist     = (seg == S_SOF) ? 1'b0 : hit;
  wire clean    = !hist && !err_now;

  assign retx_req = pending && (seg == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_error <= 1'b0;
      arb_lost  <= 1'b0;
      tx_valid  <= 1'b0;
      rx_valid  <= 1'b0;
      hit       <= 1'b0;
      pending   <= 1'b0;
      eof_idx   <= '0;
    end else begin
      bit_error <= sample && berr;
      arb_lost  <= sample && tx_active && (seg == S_ARB) && rec_dom;
      tx_valid  <= sample && eof_last && tx_active && clean;
      rx_valid  <= sample && eof_prev && !tx_active && clean;
      if (sample) begin
        hit <= hist || err_now;
        if (!in_eof)
          eof_idx <= '0;
        else if (!eof_last)
          eof_idx <= eof_idx + 1'b1;
        if (tx_active && seg == S_SOF)
          pending <= err_now;
        else if (tx_active && err_now)
          pending <= 1'b1;
      end
    end
  end
endmodule

module frame_check_monitor_chk #(
  parameter int EOF_LEN = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sample,
  input logic [2:0] seg,
  input logic       tx_active,
  input logic       tx_bit,
  input logic       rx_bit,
  input logic       err_in,
  input logic       bit_error,
  input logic       arb_lost,
  input logic       tx_valid,
  input logic       rx_valid,
  input logic       retx_req
);
  a_r1_strobed_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    bit_error |-> $past(sample) && $past(tx_active) && ($past(tx_bit) != $past(rx_bit)));
  a_r2_arb_excuse: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && tx_active && seg == 3'd2 && tx_bit && !rx_bit) |=> (arb_lost && !bit_error));
  a_r3_ack_excuse: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && tx_active && seg == 3'd6 && tx_bit && !rx_bit) |=> (!bit_error && !arb_lost));
  a_r4_dominant_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && tx_active && !tx_bit && rx_bit) |=> bit_error);
  a_r5_rx_point: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample) && ($past(seg) == 3'd7) && !$past(tx_active));
  a_r7_tx_point: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(sample) && ($past(seg) == 3'd7) && $past(tx_active) && !$past(err_in));
  a_r9_retx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> (seg == 3'd0));
endmodule

bind frame_check_monitor frame_check_monitor_chk #(.EOF_LEN(EOF_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample), .seg(seg), .tx_active(tx_active),
  .tx_bit(tx_bit), .rx_bit(rx_bit), .err_in(err_in), .bit_error(bit_error),
  .arb_lost(arb_lost), .tx_valid(tx_valid), .rx_valid(rx_valid), .retx_req(retx_req)
);

// File: tb/tb_frame_check_monitor.sv
`timescale 1ns/1ps
module tb_frame_check_monitor;
  localparam int EOF_LEN = 7;
  localparam int NV = 41;
  // {seg, tx_active tx_bit rx_bit err_in, exp bit_error arb_lost tx_valid rx_valid}
  localparam logic [10:0] VEC [NV] = '{
    {3'd1,4'b0100,4'b0000},{3'd2,4'b0110,4'b0000},{3'd2,4'b0100,4'b0000},{3'd3,4'b0110,4'b0000},
    {3'd4,4'b0100,4'b0000},{3'd5,4'b0110,4'b0000},{3'd6,4'b0100,4'b0000},{3'd5,4'b0110,4'b0000},
    {3'd7,4'b0110,4'b0000},{3'd7,4'b0110,4'b0000},{3'd7,4'b0110,4'b0000},{3'd7,4'b0110,4'b0000},
    {3'd7,4'b0110,4'b0000},{3'd7,4'b0110,4'b0001},{3'd7,4'b0100,4'b0000},
    {3'd1,4'b1000,4'b0000},{3'd2,4'b1110,4'b0000},{3'd2,4'b1000,4'b0000},{3'd3,4'b1000,4'b0000},
    {3'd6,4'b1100,4'b0000},{3'd5,4'b1110,4'b0000},
    {3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},
    {3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0010},
    {3'd1,4'b1000,4'b0000},{3'd3,4'b1010,4'b1000},
    {3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},
    {3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd7,4'b1110,4'b0000},{3'd0,4'b0110,4'b0000},
    {3'd1,4'b1000,4'b0000},{3'd2,4'b1100,4'b0100},{3'd2,4'b1010,4'b1000}
  };

  logic clk = 1'b0, rst_n = 1'b0, sample = 1'b0;
  logic [2:0] seg = 3'd0;
  logic tx_active = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1, err_in = 1'b0;
  logic bit_error, arb_lost, tx_valid, rx_valid, retx_req;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  frame_check_monitor #(.EOF_LEN(EOF_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .seg(seg), .tx_active(tx_active),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .err_in(err_in), .bit_error(bit_error),
    .arb_lost(arb_lost), .tx_valid(tx_valid), .rx_valid(rx_valid), .retx_req(retx_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] s, input logic a, input logic b, input logic r, input logic e);
    @(negedge clk);
    seg = s; tx_active = a; tx_bit = b; rx_bit = r; err_in = e; sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample = 1'b0; seg = 3'd0; tx_active = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1; err_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic eof_run(input logic a, input int dom_at, input int err_at,
                         output logic tv, output logic rv, output int rv_at);
    tv = 1'b0; rv = 1'b0; rv_at = -1;
    for (int k = 0; k < EOF_LEN; k++) begin
      put(3'd7, a, 1'b1, (k == dom_at) ? 1'b0 : 1'b1, k == err_at);
      if (tx_valid) tv = 1'b1;
      if (rx_valid) begin rv = 1'b1; rv_at = k; end
    end
  endtask

  initial begin
    logic tv, rv;
    int at;
    do_reset();
    // R10
    chk("R10 bit_error after reset", bit_error, 1'b0);
    chk("R10 arb_lost after reset", arb_lost, 1'b0);
    chk("R10 tx_valid after reset", tx_valid, 1'b0);
    chk("R10 rx_valid after reset", rx_valid, 1'b0);
    chk("R10 retx_req after reset", retx_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      put(v[10:8], v[7], v[6], v[5], v[4]);
      chk($sformatf("R1/R4 bit_error vector %0d", i), bit_error, v[3]);
      chk($sformatf("R2/R3 arb_lost vector %0d", i), arb_lost, v[2]);
      chk($sformatf("R7 tx_valid vector %0d", i), tx_valid, v[1]);
      chk($sformatf("R5 rx_valid vector %0d", i), rx_valid, v[0]);
    end

    do_reset();
    // R8: error in data suppresses, next SOF clears history
    put(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    put(3'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    eof_run(1'b0, -1, -1, tv, rv, at);
    chk("R8 rx_valid after err_in", rv, 1'b0);
    put(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    put(3'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    eof_run(1'b0, -1, -1, tv, rv, at);
    chk("R8 rx_valid after clean SOF", rv, 1'b1);
    chk("R5 rx_valid at EOF bit EOF_LEN-2", at == EOF_LEN - 2, 1'b1);
    chk("R5 no tx_valid for receiver", tv, 1'b0);

    // R6
    put(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    eof_run(1'b0, 2, -1, tv, rv, at);
    chk("R6 dominant early EOF bit", rv, 1'b0);
    put(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    eof_run(1'b0, EOF_LEN - 1, -1, tv, rv, at);
    chk("R6 dominant last EOF bit tolerated", rv, 1'b1);
    put(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    eof_run(1'b0, -1, EOF_LEN - 1, tv, rv, at);
    chk("R6 error on last EOF bit ignored by receiver", rv, 1'b1);

    // R7 / R9
    put(3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    eof_run(1'b1, -1, EOF_LEN - 1, tv, rv, at);
    chk("R7 tx_valid withheld on last-bit error", tv, 1'b0);
    @(negedge clk); seg = 3'd0; #1;
    chk("R9 retx_req on idle after failure", retx_req, 1'b1);
    @(negedge clk); seg = 3'd3; #1;
    chk("R9 retx_req low outside idle", retx_req, 1'b0);
    put(3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); seg = 3'd0; #1;
    chk("R9 retx_req cleared by new SOF", retx_req, 1'b0);
    put(3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    eof_run(1'b1, -1, -1, tv, rv, at);
    chk("R7 tx_valid clean frame", tv, 1'b1);
    chk("R5 no rx_valid while transmitting", rv, 1'b0);

    // R1 without strobe
    @(negedge clk); seg = 3'd3; tx_active = 1'b1; tx_bit = 1'b0; rx_bit = 1'b1; sample = 1'b0;
    @(negedge clk);
    chk("R1 no bit_error without sample", bit_error, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule